// File: doc/BRIEF.md
# Decimal-Aware Add/Subtract Bus Sequencer

This block runs the bus side of one add-with-carry or subtract-with-borrow instruction of an 8-bit processor core. It supports three addressing forms: immediate, zero page and absolute. Each cycle it drives an address and a read strobe. It captures the address bytes and the operand as they return on the read data bus. On the last cycle it presents the new accumulator value and the carry.

When the decimal flag is set, the arithmetic is packed BCD, two digits per byte. The sequence also gains one extra read cycle at its end, and the data returned by that read is thrown away. The parameter `DUMMY_SRC` selects where that discarded read goes. A value of 0 sends it to the address of the next instruction. Values 1 to 3 send it to a fixed zero-page location chosen by the operation, which reproduces different silicon variants. In binary mode there is no extra cycle and the arithmetic is plain 8-bit.

A one-cycle `start` pulse on an idle sequencer latches the operation, mode, flags, PC and accumulator. The first bus cycle, T0, follows on the next clock.

Top module: `bcd_addsub_seq`

## Requirements
- R1: A synchronous reset, including one applied in the middle of an instruction, returns the block to idle. From the following cycle `rd_en` and `done` are low until the next accepted `start`.
- R2: In the first cycle after an accepted `start` (T0), the block reads at the latched PC with `rd_en` high.
- R3: Immediate form (`mode` = 0): T1 reads the operand at PC+1. The sequence is 2 cycles long in binary mode and 3 in decimal mode.
- R4: Zero-page form (`mode` = 1): T1 reads the low address byte at PC+1, and T2 reads the operand at address {8'h00, low}. The sequence is 3 cycles long in binary mode and 4 in decimal mode.
- R5: Absolute form (`mode` = 2 or 3): T1 reads the low byte at PC+1 and T2 reads the high byte at PC+2. T3 reads the operand at {high, low}. The sequence is 4 cycles long in binary mode and 5 in decimal mode.
- R6: The extra final read cycle occurs only when `dec_flag` was set at `start`. It always follows the operand read.
- R7: With `DUMMY_SRC` = 0, the extra read goes to PC plus the instruction length.
- R8: With `DUMMY_SRC` of 1, 2 or 3, the extra read goes to a zero-page address. For add (`op_sub` = 0) the addresses are 8'h59, 8'h7F and 8'h56 in that order. For subtract (`op_sub` = 1) they are 8'hB1, 8'hB8 and 8'h5C.
- R9: Data returned during the extra read has no effect on `result` or `carry_out`.
- R10: Decimal add: `result` is the two-digit BCD value of (A + operand + carry_in) mod 100. `carry_out` is 1 when that sum exceeds 99.
- R11: Decimal subtract: `result` is the BCD value of (A − operand − (1 − carry_in)) mod 100. `carry_out` is 1 when no borrow occurred.
- R12: Binary mode: add gives A + operand + carry_in. Subtract gives A − operand − (1 − carry_in). `carry_out` is bit 8 of the add, or the inverse of the borrow for the subtract.
- R13: `done` is high for exactly the final bus cycle of the sequence. `result` and `carry_out` are valid in that cycle and are held afterwards. `pc_next` equals PC+2 for immediate and zero page, and PC+3 for absolute.
- R14: A `start` received while a sequence is running is ignored: the running sequence and its latched inputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an instruction when idle |
| op_sub | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| mode | input | 2 | 0 immediate, 1 zero page, 2/3 absolute |
| dec_flag | input | 1 | Decimal mode flag |
| carry_in | input | 1 | Carry flag before the instruction |
| pc_in | input | ADDR_W | Address of the opcode |
| acc_in | input | 8 | Accumulator before the instruction |
| rdata | input | 8 | Read data bus |
| addr | output | ADDR_W | Bus address |
| rd_en | output | 1 | Read strobe |
| result | output | 8 | New accumulator value |
| carry_out | output | 1 | New carry flag |
| done | output | 1 | Final cycle of the instruction |
| pc_next | output | ADDR_W | Address of the following instruction |

## Verification
Most internal faults in this block show up on the address bus within a cycle. A wrong state transition, a lost address byte or a bad dummy-address choice puts a wrong value on `addr`, or an extra or missing `rd_en` cycle, in the very cycle it happens. A scoreboard that expects every bus cycle in order therefore catches it. Arithmetic faults and a wrongly captured operand stay hidden until the `done` cycle, where `result` and `carry_out` are compared with a reference. That reference converts the BCD bytes to integers rather than adjusting nibbles. Two instances with different `DUMMY_SRC` settings run the same instructions, so both dummy-address rules are exercised. Junk data returned on the dummy read exposes any leak of that data into the result.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_OPC   = 3'd1,
    S_ARG1  = 3'd2,
    S_ARG2  = 3'd3,
    S_DATA  = 3'd4,
    S_DUMMY = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] res;
    logic              cy;
  } alu_out_t;

  function automatic logic mode_is_abs(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_is_imm(input logic [1:0] m);
    return (m == 2'd0);
  endfunction

  function automatic logic [1:0] instr_len(input logic [1:0] m);
    return mode_is_abs(m) ? 2'd3 : 2'd2;
  endfunction

  function automatic logic is_bcd(input logic [7:0] v);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
  endfunction

  // packed-BCD add, nibble by nibble with +6 correction
  function automatic alu_out_t bcd_add(input logic [7:0] a, input logic [7:0] b,
                                       input logic c);
    logic [4:0] lo, hi;
    logic c1, c2;
    lo = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, c};
    c1 = (lo > 5'd9);
    if (c1) lo = lo + 5'd6;
    hi = {1'b0, a[7:4]} + {1'b0, b[7:4]} + {4'b0, c1};
    c2 = (hi > 5'd9);
    if (c2) hi = hi + 5'd6;
    return '{res: {hi[3:0], lo[3:0]}, cy: c2};
  endfunction

  // packed-BCD subtract, nibble by nibble with -6 correction on borrow
  function automatic alu_out_t bcd_sub(input logic [7:0] a, input logic [7:0] b,
                                       input logic c);
    logic [4:0] lo, hi;
    logic b1, b2;
    lo = {1'b0, a[3:0]} - {1'b0, b[3:0]} - {4'b0, ~c};
    b1 = lo[4];
    if (b1) lo = lo - 5'd6;
    hi = {1'b0, a[7:4]} - {1'b0, b[7:4]} - {4'b0, b1};
    b2 = hi[4];
    if (b2) hi = hi - 5'd6;
    return '{res: {hi[3:0], lo[3:0]}, cy: ~b2};
  endfunction

  function automatic alu_out_t bin_add(input logic [7:0] a, input logic [7:0] b,
                                       input logic c);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b} + {8'b0, c};
    return '{res: s[7:0], cy: s[8]};
  endfunction

  function automatic alu_out_t bin_sub(input logic [7:0] a, input logic [7:0] b,
                                       input logic c);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, ~b} + {8'b0, c};
    return '{res: s[7:0], cy: s[8]};
  endfunction

  function automatic alu_out_t alu_eval(input logic sub, input logic dec,
                                        input logic [7:0] a, input logic [7:0] b,
                                        input logic c);
    alu_out_t r;
    case ({dec, sub})
      2'b00:   r = bin_add(a, b, c);
      2'b01:   r = bin_sub(a, b, c);
      2'b10:   r = bcd_add(a, b, c);
      default: r = bcd_sub(a, b, c);
    endcase
    return r;
  endfunction

  // zero-page target of the discarded read for the fixed-address variants
  function automatic logic [7:0] fixed_dummy(input int variant, input logic sub);
    logic [7:0] r;
    case (variant)
      1:       r = sub ? 8'hB1 : 8'h59;
      2:       r = sub ? 8'hB8 : 8'h7F;
      default: r = sub ? 8'h5C : 8'h56;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       op_i,
  input  logic [1:0] mode_i,
  input  logic       dec_i,
  output seq_state_e state_o,
  output logic       accept_o,
  output logic       op_q_o,
  output logic [1:0] mode_q_o,
  output logic       dec_q_o,
  output logic       opnd_cyc_o,
  output logic       lo_cyc_o,
  output logic       hi_cyc_o,
  output logic       dummy_cyc_o,
  output logic       last_cyc_o,
  output logic       rd_en_o
);

  seq_state_e state, nxt;
  logic       op_q, dec_q;
  logic [1:0] mode_q;
  logic       imm_q, abs_q;

  assign imm_q    = mode_is_imm(mode_q);
  assign abs_q    = mode_is_abs(mode_q);
  assign accept_o = start && (state == S_IDLE);

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:  if (accept_o) nxt = S_OPC;
      S_OPC:   nxt = S_ARG1;
      S_ARG1:  begin
        if (imm_q)      nxt = dec_q ? S_DUMMY : S_IDLE;
        else if (abs_q) nxt = S_ARG2;
        else            nxt = S_DATA;
      end
      S_ARG2:  nxt = S_DATA;
      S_DATA:  nxt = dec_q ? S_DUMMY : S_IDLE;
      S_DUMMY: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      op_q   <= 1'b0;
      mode_q <= 2'd0;
      dec_q  <= 1'b0;
    end else begin
      state <= nxt;
      if (accept_o) begin
        op_q   <= op_i;
        mode_q <= mode_i;
        dec_q  <= dec_i;
      end
    end
  end

  assign opnd_cyc_o  = ((state == S_ARG1) && imm_q) || (state == S_DATA);
  assign lo_cyc_o    = (state == S_ARG1) && !imm_q;
  assign hi_cyc_o    = (state == S_ARG2);
  assign dummy_cyc_o = (state == S_DUMMY);
  assign last_cyc_o  = dummy_cyc_o || (opnd_cyc_o && !dec_q);
  assign rd_en_o     = (state != S_IDLE);
  assign state_o     = state;
  assign op_q_o      = op_q;
  assign mode_q_o    = mode_q;
  assign dec_q_o     = dec_q;

  AST_RST_IDLE: assert property (@(posedge clk) rst |=> !rd_en_o); // R1
  AST_DUMMY_DEC: assert property (@(posedge clk) disable iff (rst)
    dummy_cyc_o |-> dec_q); // R6
  AST_DUMMY_AFTER_OPND: assert property (@(posedge clk) disable iff (rst)
    dummy_cyc_o |-> $past(opnd_cyc_o)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    last_cyc_o |=> !last_cyc_o); // R13
  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
    (start && state != S_IDLE) |=> (state != S_OPC)); // R14
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE && state != S_OPC) |-> $stable(mode_q) && $stable(op_q)); // R14

endmodule

// File: rtl/seq_addr.sv
module seq_addr
  import seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DUMMY_SRC = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  seq_state_e        state_i,
  input  logic [1:0]        mode_q_i,
  input  logic              op_q_i,
  input  logic [7:0]        rdata_i,
  input  logic              lo_cyc_i,
  input  logic              hi_cyc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] pc_next_o
);

  localparam int HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] pc_q;
  logic [7:0]        lo_q;
  logic [7:0]        hi_q;
  logic [ADDR_W-1:0] zp_addr, abs_addr, dummy_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      lo_q <= 8'h00;
      hi_q <= 8'h00;
    end else begin
      if (accept_i) pc_q <= pc_i;
      if (lo_cyc_i) lo_q <= rdata_i;
      if (hi_cyc_i) hi_q <= rdata_i;
    end
  end

  assign pc_next_o = pc_q + {{(ADDR_W-2){1'b0}}, instr_len(mode_q_i)};
  assign zp_addr   = {{HI_W{1'b0}}, lo_q};
  assign abs_addr  = {{(HI_W-8){1'b0}}, hi_q, lo_q};

  generate
    if (DUMMY_SRC == 0) begin : g_dummy_pc
      assign dummy_addr = pc_next_o;
    end else begin : g_dummy_fixed
      assign dummy_addr = {{HI_W{1'b0}}, fixed_dummy(DUMMY_SRC, op_q_i)};
      AST_FIXED_ZP: assert property (@(posedge clk) disable iff (rst)
        (state_i == S_DUMMY) |-> (addr_o[ADDR_W-1:8] == '0)); // R8
    end
  endgenerate

  always_comb begin
    case (state_i)
      S_OPC:   addr_o = pc_q;
      S_ARG1:  addr_o = pc_q + {{(ADDR_W-1){1'b0}}, 1'b1};
      S_ARG2:  addr_o = pc_q + {{(ADDR_W-2){1'b0}}, 2'd2};
      S_DATA:  addr_o = mode_is_abs(mode_q_i) ? abs_addr : zp_addr;
      S_DUMMY: addr_o = dummy_addr;
      default: addr_o = '0;
    endcase
  end

  AST_FETCH_PC: assert property (@(posedge clk) disable iff (rst)
    (state_i == S_OPC) |-> (addr_o == $past(pc_i))); // R2
  AST_ARG_STEP: assert property (@(posedge clk) disable iff (rst)
    (state_i == S_ARG1) |-> (addr_o == $past(addr_o) + 1'b1)); // R3
  AST_ZP_PAGE: assert property (@(posedge clk) disable iff (rst)
    (state_i == S_DATA && !mode_is_abs(mode_q_i)) |-> (addr_o[ADDR_W-1:8] == '0)); // R4
  AST_ABS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state_i == S_DATA && mode_is_abs(mode_q_i)) |-> (addr_o[15:8] == $past(rdata_i))); // R5

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        accept_i,
  input  logic [7:0]  acc_i,
  input  logic        cin_i,
  input  logic [7:0]  rdata_i,
  input  logic        op_q_i,
  input  logic        dec_q_i,
  input  logic        opnd_cyc_i,
  input  logic        dummy_cyc_i,
  input  logic        last_cyc_i,
  output logic [7:0]  result_o,
  output logic        carry_o
);

  logic [7:0] acc_q, opnd_q, opnd_v, res_q;
  logic       cin_q, cy_q;
  alu_out_t   fresh;

  assign opnd_v = opnd_cyc_i ? rdata_i : opnd_q;
  assign fresh  = alu_eval(op_q_i, dec_q_i, acc_q, opnd_v, cin_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= 8'h00;
      cin_q  <= 1'b0;
      opnd_q <= 8'h00;
      res_q  <= 8'h00;
      cy_q   <= 1'b0;
    end else begin
      if (accept_i) begin
        acc_q <= acc_i;
        cin_q <= cin_i;
      end
      if (opnd_cyc_i) opnd_q <= rdata_i;
      if (last_cyc_i) begin
        res_q <= fresh.res;
        cy_q  <= fresh.cy;
      end
    end
  end

  assign result_o = last_cyc_i ? fresh.res : res_q;
  assign carry_o  = last_cyc_i ? fresh.cy  : cy_q;

  AST_DUMMY_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    dummy_cyc_i |=> $stable(opnd_q)); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (last_cyc_i && !accept_i) |=> ($stable(result_o) && $stable(carry_o))); // R13
  AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (rst)
    (last_cyc_i && dec_q_i && is_bcd(acc_q) && is_bcd(opnd_v)) |-> is_bcd(result_o)); // R10

endmodule

// File: rtl/bcd_addsub_seq.sv
module bcd_addsub_seq
  import seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DUMMY_SRC = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_sub,
  input  logic [1:0]        mode,
  input  logic              dec_flag,
  input  logic              carry_in,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [7:0]        acc_in,
  input  logic [7:0]        rdata,
  output logic [ADDR_W-1:0] addr,
  output logic              rd_en,
  output logic [7:0]        result,
  output logic              carry_out,
  output logic              done,
  output logic [ADDR_W-1:0] pc_next
);

  seq_state_e state;
  logic       accept, op_q, dec_q;
  logic [1:0] mode_q;
  logic       opnd_cyc, lo_cyc, hi_cyc, dummy_cyc, last_cyc;

  seq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .op_i       (op_sub),
    .mode_i     (mode),
    .dec_i      (dec_flag),
    .state_o    (state),
    .accept_o   (accept),
    .op_q_o     (op_q),
    .mode_q_o   (mode_q),
    .dec_q_o    (dec_q),
    .opnd_cyc_o (opnd_cyc),
    .lo_cyc_o   (lo_cyc),
    .hi_cyc_o   (hi_cyc),
    .dummy_cyc_o(dummy_cyc),
    .last_cyc_o (last_cyc),
    .rd_en_o    (rd_en)
  );

  seq_addr #(.ADDR_W(ADDR_W), .DUMMY_SRC(DUMMY_SRC)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .accept_i (accept),
    .pc_i     (pc_in),
    .state_i  (state),
    .mode_q_i (mode_q),
    .op_q_i   (op_q),
    .rdata_i  (rdata),
    .lo_cyc_i (lo_cyc),
    .hi_cyc_i (hi_cyc),
    .addr_o   (addr),
    .pc_next_o(pc_next)
  );

  seq_datapath u_dp (
    .clk        (clk),
    .rst        (rst),
    .accept_i   (accept),
    .acc_i      (acc_in),
    .cin_i      (carry_in),
    .rdata_i    (rdata),
    .op_q_i     (op_q),
    .dec_q_i    (dec_q),
    .opnd_cyc_i (opnd_cyc),
    .dummy_cyc_i(dummy_cyc),
    .last_cyc_i (last_cyc),
    .result_o   (result),
    .carry_o    (carry_out)
  );

  assign done = last_cyc;

  AST_DONE_WITH_READ: assert property (@(posedge clk) disable iff (rst)
    done |-> rd_en); // R13

endmodule

// File: tb/tb_bcd_addsub_seq.sv
module tb_bcd_addsub_seq;

  localparam int CLK_P = 10;

  typedef struct {
    logic [15:0] a;
    bit          last;
    logic [7:0]  r;
    bit          c;
    logic [15:0] np;
    string       rq;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        op_sub = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        dec_flag = 1'b0;
  logic        carry_in = 1'b0;
  logic [15:0] pc_in = 16'h0;
  logic [7:0]  acc_in = 8'h0;

  logic [7:0]  rdata0, rdata1, res0, res1;
  logic [15:0] addr0, addr1, np0, np1;
  logic        rd0, rd1, cy0, cy1, dn0, dn1;

  // small bus model: up to three programmed locations, junk elsewhere
  bit          v1 = 0, v2 = 0, vo = 0;
  logic [15:0] m_a1, m_a2, m_oa;
  logic [7:0]  m_d1, m_d2, m_od;

  item_t q0[$];
  item_t q1[$];
  item_t it0, it1;
  int    n_chk = 0, n_fail = 0, cyc = 0;
  bit    mon_on = 0;

  always #(CLK_P/2) clk = ~clk;

  always_comb begin
    if (v1 && addr0 == m_a1)      rdata0 = m_d1;
    else if (v2 && addr0 == m_a2) rdata0 = m_d2;
    else if (vo && addr0 == m_oa) rdata0 = m_od;
    else                          rdata0 = addr0[7:0] ^ 8'h3C;
  end

  always_comb begin
    if (v1 && addr1 == m_a1)      rdata1 = m_d1;
    else if (v2 && addr1 == m_a2) rdata1 = m_d2;
    else if (vo && addr1 == m_oa) rdata1 = m_od;
    else                          rdata1 = addr1[7:0] ^ 8'h3C;
  end

  bcd_addsub_seq #(.ADDR_W(16), .DUMMY_SRC(0)) dut (
    .clk(clk), .rst(rst), .start(start), .op_sub(op_sub), .mode(mode),
    .dec_flag(dec_flag), .carry_in(carry_in), .pc_in(pc_in), .acc_in(acc_in),
    .rdata(rdata0), .addr(addr0), .rd_en(rd0), .result(res0),
    .carry_out(cy0), .done(dn0), .pc_next(np0)
  );

  bcd_addsub_seq #(.ADDR_W(16), .DUMMY_SRC(2)) dut_fx (
    .clk(clk), .rst(rst), .start(start), .op_sub(op_sub), .mode(mode),
    .dec_flag(dec_flag), .carry_in(carry_in), .pc_in(pc_in), .acc_in(acc_in),
    .rdata(rdata1), .addr(addr1), .rd_en(rd1), .result(res1),
    .carry_out(cy1), .done(dn1), .pc_next(np1)
  );

  task automatic chk(input bit ok, input string msg, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // reference arithmetic on integers (not nibble adjustment)
  function automatic logic [8:0] ref_calc(bit sub, bit dec, logic [7:0] a,
                                          logic [7:0] b, bit c);
    int av, bv, s;
    bit cy;
    if (dec) begin
      av = int'(a[7:4]) * 10 + int'(a[3:0]);
      bv = int'(b[7:4]) * 10 + int'(b[3:0]);
      if (!sub) begin
        s = av + bv + int'(c);
        cy = (s > 99);
        s = s % 100;
      end else begin
        s = av - bv - (1 - int'(c));
        cy = (s >= 0);
        if (s < 0) s = s + 100;
      end
      return {cy, 4'(s / 10), 4'(s % 10)};
    end else begin
      if (!sub) begin
        s = int'(a) + int'(b) + int'(c);
        cy = (s > 255);
      end else begin
        s = int'(a) - int'(b) - (1 - int'(c));
        cy = (s >= 0);
      end
      return {cy, 8'(s)};
    end
  endfunction

  function automatic logic [7:0] fx_addr(bit sub);
    return sub ? 8'hB8 : 8'h7F; // DUMMY_SRC = 2 (R8)
  endfunction

  task automatic push2(input logic [15:0] a0, input logic [15:0] a1, input bit last,
                       input logic [8:0] rc, input logic [15:0] np, input string rq);
    item_t i;
    i.last = last; i.r = rc[7:0]; i.c = rc[8]; i.np = np; i.rq = rq;
    i.a = a0; q0.push_back(i);
    i.a = a1; q1.push_back(i);
  endtask

  // drive one instruction and record its expected bus cycles
  task automatic run(input bit sub, input logic [1:0] md, input bit dec, input bit cin,
                     input logic [15:0] pc, input logic [7:0] acc, input logic [7:0] opnd,
                     input logic [7:0] lo, input logic [7:0] hi, input string rq,
                     input bit busy_start);
    logic [15:0] np, oa;
    logic [8:0]  rc;
    bit          ab, im;
    ab = md[1];
    im = (md == 2'd0);
    np = pc + (ab ? 16'd3 : 16'd2);
    rc = ref_calc(sub, dec, acc, opnd, cin);
    oa = ab ? {hi, lo} : {8'h00, lo};
    v1 = 1; m_a1 = pc + 16'd1; m_d1 = im ? opnd : lo;
    v2 = ab; m_a2 = pc + 16'd2; m_d2 = hi;
    vo = !im; m_oa = oa; m_od = opnd;
    @(negedge clk);
    op_sub = sub; mode = md; dec_flag = dec; carry_in = cin; pc_in = pc; acc_in = acc;
    start = 1'b1;
    @(posedge clk);
    push2(pc, pc, 0, rc, np, {rq, " R2 fetch"});
    if (im) begin
      push2(pc + 16'd1, pc + 16'd1, !dec, rc, np, {rq, " R3 operand"});
    end else begin
      push2(pc + 16'd1, pc + 16'd1, 0, rc, np, {rq, " low byte"});
      if (ab) push2(pc + 16'd2, pc + 16'd2, 0, rc, np, {rq, " R5 high byte"});
      push2(oa, oa, !dec, rc, np, {rq, " operand"});
    end
    if (dec) push2(np, {8'h00, fx_addr(sub)}, 1, rc, np, {rq, " R6 R7 R8 dummy"});
    @(negedge clk);
    start = 1'b0;
    if (busy_start) begin
      // R14: a second start with different inputs while busy
      @(negedge clk);
      start = 1'b1; pc_in = 16'h1234; acc_in = 8'h00; mode = 2'd0;
      op_sub = ~sub; dec_flag = ~dec;
      @(negedge clk);
      start = 1'b0;
    end
    while (q0.size() != 0 || q1.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitors
  always @(negedge clk) begin
    if (mon_on) begin
      if (rd0) begin
        if (q0.size() == 0) chk(0, "R14 unexpected bus cycle (dut)", addr0, 0);
        else begin
          it0 = q0.pop_front();
          chk(addr0 == it0.a, {it0.rq, " addr"}, addr0, it0.a);
          chk(dn0 == it0.last, {it0.rq, " R13 done"}, dn0, it0.last);
          if (it0.last) begin
            chk(res0 == it0.r, {it0.rq, " R9 R10 R11 R12 result"}, res0, it0.r);
            chk(cy0 == it0.c, {it0.rq, " carry"}, cy0, it0.c);
            chk(np0 == it0.np, {it0.rq, " R13 pc_next"}, np0, it0.np);
          end
        end
      end else if (q0.size() != 0) chk(0, "R3 R4 R5 missing bus cycle (dut)", 0, q0[0].a);
      if (rd1) begin
        if (q1.size() == 0) chk(0, "R14 unexpected bus cycle (dut_fx)", addr1, 0);
        else begin
          it1 = q1.pop_front();
          chk(addr1 == it1.a, {it1.rq, " fx addr"}, addr1, it1.a);
          if (it1.last) chk(res1 == it1.r, {it1.rq, " fx result"}, res1, it1.r);
        end
      end else if (q1.size() != 0) chk(0, "R6 missing bus cycle (dut_fx)", 0, q1[0].a);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(0, "R13 watchdog expired", cyc, 0);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rd0 && !dn0, "R1 reset rd_en/done", {rd0, dn0}, 0);
    chk(res0 == 8'h00, "R1 reset result", res0, 0);
    rst = 1'b0;
    mon_on = 1;
    @(negedge clk);
    // immediate
    run(0, 2'd0, 1, 0, 16'h4000, 8'h45, 8'h38, 8'h00, 8'h00, "R3 R10 imm add", 0);
    run(0, 2'd0, 1, 0, 16'h4010, 8'h99, 8'h01, 8'h00, 8'h00, "R10 imm add wrap", 0);
    run(0, 2'd0, 1, 1, 16'h4020, 8'h58, 8'h41, 8'h00, 8'h00, "R10 imm add cin", 0);
    run(1, 2'd0, 1, 1, 16'h4030, 8'h50, 8'h25, 8'h00, 8'h00, "R11 imm sub", 0);
    run(1, 2'd0, 1, 1, 16'h4040, 8'h00, 8'h01, 8'h00, 8'h00, "R11 imm sub borrow", 0);
    run(1, 2'd0, 1, 0, 16'h4050, 8'h42, 8'h12, 8'h00, 8'h00, "R11 imm sub cin0", 0);
    run(0, 2'd0, 0, 1, 16'h4060, 8'h7F, 8'h80, 8'h00, 8'h00, "R12 R6 imm bin add", 0);
    // zero page
    run(0, 2'd1, 1, 0, 16'h4100, 8'h27, 8'h36, 8'h20, 8'h00, "R4 R10 zp add", 0);
    run(1, 2'd1, 0, 1, 16'h4110, 8'h10, 8'h20, 8'h21, 8'h00, "R4 R12 zp bin sub", 0);
    run(1, 2'd1, 1, 1, 16'h4120, 8'h31, 8'h19, 8'h22, 8'h00, "R4 R11 zp sub", 0);
    // absolute
    run(0, 2'd2, 1, 1, 16'h4200, 8'h64, 8'h35, 8'h44, 8'h52, "R5 R10 abs add", 0);
    run(1, 2'd3, 1, 1, 16'h4210, 8'h12, 8'h34, 8'h48, 8'h53, "R5 R11 abs sub", 0);
    run(0, 2'd2, 0, 1, 16'h4220, 8'hF0, 8'h20, 8'h4C, 8'h54, "R5 R12 abs bin add", 0);
    // R14: start while busy
    run(0, 2'd2, 1, 0, 16'h4300, 8'h08, 8'h09, 8'h60, 8'h55, "R14 busy start", 1);
    run(1, 2'd0, 0, 0, 16'h4310, 8'h05, 8'h07, 8'h00, 8'h00, "R14 busy start bin", 1);
    // R1: reset in the middle of an instruction
    mon_on = 0;
    @(negedge clk);
    mode = 2'd2; dec_flag = 1; pc_in = 16'h4400; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!rd0 && !dn0 && !rd1, "R1 mid-run reset", {rd0, dn0, rd1}, 0);
    @(negedge clk);
    chk(!rd0, "R1 reset hold", rd0, 0);
    rst = 1'b0;
    q0.delete(); q1.delete();
    @(negedge clk);
    chk(!rd0 && !rd1, "R1 idle after reset", {rd0, rd1}, 0);
    mon_on = 1;
    run(0, 2'd1, 1, 1, 16'h4500, 8'h89, 8'h10, 8'h30, 8'h00, "R1 R10 after reset", 0);
    summary();
  end

endmodule